// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives a clause-22 PHY management bus from a small register port. Software packs a complete 32-bit management frame into one maintenance register: start marker, opcode, PHY address, register number, turnaround and data. Writing that register while the interface is idle and enabled launches a transaction. The block sends a run of preamble ones, then shifts the packed word out MSB first on MDIO, clocked by a management clock derived from the bus clock.

For a read, the block stops driving MDIO for the turnaround and data bits and shifts the sixteen bits the PHY returns into the low half of the same maintenance register. The upper half keeps the command that was sent. A status bit reports when the interface is idle again and can accept the next word. The management clock is the bus clock divided by 32 or 48, and the divider is chosen by a two-bit configuration field.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset the status reads 0x4 (idle), the maintenance word reads 0, the configuration reads 0x2, and both `mdc` and `mdioOe` are low.
- R2: Registers are selected by the word index `regIdx`: 0 is control (bit 4 = management enable), 1 is configuration (bits [1:0] = divider select), 2 is status (bit 2 = idle), and 3 is the maintenance word. Written control and configuration values read back.
- R3: An accepted frame shows 32 MDC cycles with MDIO high and driven, followed by the 32 maintenance-word bits, bit 31 first. Bits [31:30] = 01 is the start marker, bits [29:28] the opcode, [27:23] the PHY address, [22:18] the register number, [17:16] the turnaround, and [15:0] the data.
- R4: One MDC period is 48 bus clocks when the divider select is 0b11 and 32 bus clocks for any other value. MDC stays low while idle.
- R5: MDIO output changes only on falling MDC edges. Returned data is sampled on rising MDC edges.
- R6: A word with bit 29 set is a read. `mdioOe` is low for word bits 17 down to 0. The 16 sampled bits, first-received as bit 15, replace maintenance bits [15:0], and bits [31:16] are unchanged. A word with bit 29 clear keeps `mdioOe` high for the whole frame.
- R7: Status bit 2 reads 0 from the accepted maintenance write until the final bit's falling MDC edge.
- R8: A maintenance write while the interface is busy is ignored. The register and the frame on the wire are unchanged, and no second frame follows.
- R9: With the enable bit clear, a maintenance write is ignored. No frame starts, the idle flag stays 1 and the register keeps its value.
- R10: Clearing the enable bit during a frame aborts it. The idle flag returns to 1, and MDC and `mdioOe` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 2 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regIdx` (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output data |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input data |

## Verification
The bench builds the block with its default parameters: dividers of 32 and 48 and a 32-bit preamble. These are the real frame lengths, so every bit position, including the turnaround release and the last data bit, is checked on full frames. Both divider encodings and the fallback encoding are run, and each is checked by measuring the MDC period. A PHY model in the bench drives read data with set first and last bits (0x8001) and patterned data, so both ends of the capture shift are exercised. A busy write, a disabled write and a mid-frame abort are also covered.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } mdioState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftOut;   // present next frame bit (falling MDC)
    logic sampleIn;   // capture a read data bit (rising MDC)
    logic finish;     // last bit done
  } mdioStrobe_t;

  localparam logic [1:0] IDX_CTRL  = 2'd0;
  localparam logic [1:0] IDX_CFG   = 2'd1;
  localparam logic [1:0] IDX_STAT  = 2'd2;
  localparam logic [1:0] IDX_MAINT = 2'd3;

  localparam int EN_BIT      = 4;
  localparam int IDLE_BIT    = 2;
  localparam int READ_OP_BIT = 29;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_master_pkg::*;
#(
  parameter int DIV_FAST  = 32,
  parameter int DIV_SLOW  = 48,
  parameter int PRE_LEN   = 32,
  parameter int FRAME_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mgmtEn,
  input  logic        startReq,
  input  logic        startRead,
  input  logic [1:0]  divSel,
  output logic        mdc,
  output logic        mdioOe,
  output logic        idle,
  output mdioStrobe_t strb
);

  localparam int TOTAL    = PRE_LEN + FRAME_LEN;
  localparam int IDX_W    = $clog2(TOTAL);
  localparam int HALF_MAX = (DIV_SLOW > DIV_FAST ? DIV_SLOW : DIV_FAST) / 2;
  localparam int HC_W     = $clog2(HALF_MAX) + 1;
  localparam logic [IDX_W:0]  REL_IDX  = (IDX_W+1)'(TOTAL - 18);
  localparam logic [IDX_W:0]  DATA_IDX = (IDX_W+1)'(TOTAL - 16);
  localparam logic [IDX_W:0]  PRE_IDX  = (IDX_W+1)'(PRE_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [HC_W-1:0] HALF_FAST = HC_W'(DIV_FAST / 2 - 1);
  localparam logic [HC_W-1:0] HALF_SLOW = HC_W'(DIV_SLOW / 2 - 1);

  mdioState_t       state;
  logic [HC_W-1:0]  halfCnt, halfLen;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W:0]   nextIdx;
  logic             mdcQ, oeQ, readQ;
  logic             tick, riseTick, fallTick, lastBit;

  assign tick     = (state == ST_RUN) && mgmtEn && (halfCnt == halfLen);
  assign riseTick = tick && !mdcQ;
  assign fallTick = tick && mdcQ;
  assign lastBit  = (bitIdx == LAST_IDX);
  assign nextIdx  = {1'b0, bitIdx} + 1'b1;

  always_comb begin
    strb          = '0;
    strb.shiftOut = fallTick && !lastBit && (nextIdx >= PRE_IDX);
    strb.sampleIn = riseTick && readQ && ({1'b0, bitIdx} >= DATA_IDX);
    strb.finish   = fallTick && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      halfLen <= HALF_FAST;
      bitIdx  <= '0;
      mdcQ    <= 1'b0;
      oeQ     <= 1'b0;
      readQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          mdcQ <= 1'b0;
          oeQ  <= 1'b0;
          if (startReq) begin
            state   <= ST_RUN;
            halfCnt <= '0;
            bitIdx  <= '0;
            halfLen <= (divSel == 2'b11) ? HALF_SLOW : HALF_FAST;
            readQ   <= startRead;
            oeQ     <= 1'b1;
          end
        end
        default: begin
          if (!mgmtEn) begin
            state <= ST_IDLE;
            mdcQ  <= 1'b0;
            oeQ   <= 1'b0;
          end else if (halfCnt == halfLen) begin
            halfCnt <= '0;
            mdcQ    <= ~mdcQ;
            if (mdcQ) begin
              if (lastBit) begin
                state <= ST_IDLE;
                oeQ   <= 1'b0;
              end else begin
                bitIdx <= bitIdx + 1'b1;
                if (readQ && nextIdx >= REL_IDX) oeQ <= 1'b0;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign mdc    = mdcQ;
  assign mdioOe = oeQ;
  assign idle   = (state == ST_IDLE);

  // R4: bus quiet whenever the FSM is idle
  a_r4_mdc_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!mdcQ && !oeQ));

  // R6: a read frame never drives through turnaround and data
  a_r6_oe_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && readQ && {1'b0, bitIdx} >= REL_IDX) |-> !oeQ);

  // R9: a frame only launches with the enable set
  a_r9_start_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |-> mgmtEn);

  // R10: dropping the enable mid-frame returns to idle with MDC low
  a_r10_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !mgmtEn) |=> (state == ST_IDLE && !mdcQ));

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_master_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regIdx,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              ctrlIdle,
  input  mdioStrobe_t       strb,
  output logic              startReq,
  output logic              startRead,
  output logic              mgmtEn,
  output logic [1:0]        divSel,
  input  logic              mdioIn,
  output logic              mdioOut
);

  logic              enReg;
  logic [1:0]        divSelReg;
  logic [WORD_W-1:0] maintWord, shiftReg;
  logic [DATA_W-1:0] capReg;
  logic              mdoQ, maintWe;

  assign maintWe   = regWe && (regIdx == IDX_MAINT);
  assign startReq  = maintWe && ctrlIdle && enReg;
  assign startRead = regWrData[READ_OP_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      divSelReg <= 2'b10;
      maintWord <= '0;
      shiftReg  <= '0;
      capReg    <= '0;
      mdoQ      <= 1'b1;
    end else begin
      if (regWe && regIdx == IDX_CTRL) enReg     <= regWrData[EN_BIT];
      if (regWe && regIdx == IDX_CFG)  divSelReg <= regWrData[1:0];
      if (startReq) begin
        maintWord <= regWrData;
        shiftReg  <= regWrData;
        capReg    <= '0;
        mdoQ      <= 1'b1;
      end else begin
        if (strb.shiftOut) begin
          mdoQ     <= shiftReg[WORD_W-1];
          shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        end
        if (strb.sampleIn) capReg <= {capReg[DATA_W-2:0], mdioIn};
        if (strb.finish) begin
          mdoQ <= 1'b1;
          if (maintWord[READ_OP_BIT]) maintWord[DATA_W-1:0] <= capReg;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regIdx)
      IDX_CTRL: regRdData[EN_BIT]   = enReg;
      IDX_CFG:  regRdData[1:0]      = divSelReg;
      IDX_STAT: regRdData[IDLE_BIT] = ctrlIdle;
      default:  regRdData           = maintWord;
    endcase
  end

  assign mgmtEn  = enReg;
  assign divSel  = divSelReg;
  assign mdioOut = mdoQ;

  // R5: output bit moves only on a falling-edge strobe or frame launch
  a_r5_mdo_only_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftOut || strb.finish || startReq) |=> $stable(mdoQ));

  // R8: maintenance writes during a frame leave the word untouched
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (maintWe && !ctrlIdle && !strb.finish) |=> $stable(maintWord));

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_master_pkg::*;
#(
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 48,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regIdx,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  localparam int WORD_W = 32;

  mdioStrobe_t strb;
  logic        ctrlIdle, startReq, startRead, mgmtEn;
  logic [1:0]  divSel;

  mdio_ctrl #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW),
    .PRE_LEN  (PRE_LEN),
    .FRAME_LEN(WORD_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .mgmtEn   (mgmtEn),
    .startReq (startReq),
    .startRead(startRead),
    .divSel   (divSel),
    .mdc      (mdc),
    .mdioOe   (mdioOe),
    .idle     (ctrlIdle),
    .strb     (strb)
  );

  mdio_datapath #(
    .WORD_W(WORD_W),
    .DATA_W(16)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regIdx   (regIdx),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .ctrlIdle (ctrlIdle),
    .strb     (strb),
    .startReq (startReq),
    .startRead(startRead),
    .mgmtEn   (mgmtEn),
    .divSel   (divSel),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut)
  );

endmodule

// File: tb/mdio_frame_master_tb_top.sv
`timescale 1ns/1ps
module mdio_frame_master_tb_top;

  typedef struct {
    logic [31:0] word;
    logic [15:0] rdData;
    int          div;
  } expFrame_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regIdx = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b0;

  int checks = 0;
  int bad = 0;
  bit monIgnore = 1'b0;
  expFrame_t expQ[$];

  always #4 clk = ~clk;

  mdio_frame_master dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] idx, logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1; regIdx = idx; regWrData = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(logic [1:0] idx, output logic [31:0] data);
    @(negedge clk);
    regIdx = idx;
    #1 data = regRdData;
  endtask

  task automatic waitIdle(string tag);
    logic [31:0] st;
    for (int i = 0; i < 20000; i++) begin
      regRead(2'd2, st);
      if (st[2]) return;
    end
    check({tag, " idle timeout"}, st, 32'h4);
  endtask

  function automatic logic [31:0] mkWord(logic [1:0] op, logic [4:0] phy,
                                         logic [4:0] rg, logic [15:0] data);
    return {2'b01, op, phy, rg, 2'b10, data};
  endfunction

  // driver: push the expected frame, then launch it
  task automatic sendFrame(logic [31:0] w, logic [15:0] rd, int div);
    expFrame_t it;
    it.word = w; it.rdData = rd; it.div = div;
    expQ.push_back(it);
    regWrite(2'd3, w);
  endtask

  // monitor + PHY model
  int        cnt = 0;
  int        sinceRise = 0;
  bit        prevMdc = 1'b0;
  bit        haveItem = 1'b0;
  bit        frameBad = 1'b0;
  expFrame_t cur;

  always @(negedge clk) begin
    if (!rstN || monIgnore) begin
      cnt = 0; sinceRise = 0; haveItem = 1'b0; prevMdc = mdc;
    end else begin
      sinceRise++;
      if (mdc && !prevMdc) begin
        logic expOe, expMdo;
        if (cnt == 0) begin
          frameBad = 1'b0;
          if (expQ.size() == 0) begin
            checks++; bad++; haveItem = 1'b0;
            $display("FAIL R8 unexpected frame actual=start expected=none");
          end else begin
            cur = expQ.pop_front(); haveItem = 1'b1;
          end
        end
        if (cnt == 1 && haveItem) check("R4 mdc period", sinceRise, cur.div);
        if (cnt < 32) begin
          expOe = 1'b1; expMdo = 1'b1;
        end else begin
          int b;
          b = 63 - cnt;
          expOe = !(cur.word[29] && b <= 17);
          expMdo = cur.word[b];
        end
        if (haveItem && !frameBad &&
            (mdioOe !== expOe || (expOe && mdioOut !== expMdo))) begin
          frameBad = 1'b1;
          $display("FAIL R3/R6 bit %0d actual oe=%b d=%b expected oe=%b d=%b",
                   cnt, mdioOe, mdioOut, expOe, expMdo);
        end
        sinceRise = 0;
        cnt++;
        if (cnt == 64) begin
          if (haveItem) begin
            checks++;
            if (frameBad) bad++;
          end
          cnt = 0; haveItem = 1'b0;
        end
      end
      if (!mdc && prevMdc && haveItem && cur.word[29] && cnt >= 48)
        mdioIn = cur.rdData[63 - cnt];
      prevMdc = mdc;
    end
  end

  initial begin
    #(8 * 200000);
    checks++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd, w, lastW;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(2'd2, rd); check("R1 status", rd, 32'h4);
    regRead(2'd3, rd); check("R1 maint", rd, 32'h0);
    regRead(2'd1, rd); check("R1 cfg", rd, 32'h2);
    check("R1 mdc/oe", {30'd0, mdc, mdioOe}, 32'h0);

    // R2 enable
    regWrite(2'd0, 32'h10);
    regRead(2'd0, rd); check("R2 ctrl readback", rd, 32'h10);

    // write frame, divide 32, with a busy write (R3, R7, R8)
    w = mkWord(2'b01, 5'h03, 5'h04, 16'h1234);
    sendFrame(w, 16'h0, 32);
    repeat (100) @(negedge clk);
    regRead(2'd2, rd); check("R7 busy status", rd, 32'h0);
    regWrite(2'd3, mkWord(2'b10, 5'h1f, 5'h00, 16'hbeef));
    waitIdle("R7");
    regRead(2'd3, rd); check("R8 maint after busy write", rd, w);

    // read frame, divide 32 (R6)
    w = mkWord(2'b10, 5'h11, 5'h02, 16'h0000);
    sendFrame(w, 16'ha5c3, 32);
    waitIdle("R6");
    regRead(2'd3, rd); check("R6 read data a5c3", rd, {w[31:16], 16'ha5c3});

    // divide 48 (R4), edge data bits
    regWrite(2'd1, 32'h3);
    regRead(2'd1, rd); check("R2 cfg readback", rd, 32'h3);
    w = mkWord(2'b10, 5'h00, 5'h1f, 16'h0000);
    sendFrame(w, 16'h8001, 48);
    waitIdle("R6");
    regRead(2'd3, rd); check("R6 read data 8001", rd, {w[31:16], 16'h8001});

    w = mkWord(2'b01, 5'h1f, 5'h1f, 16'hffff);
    sendFrame(w, 16'h0, 48);
    waitIdle("R3");
    regRead(2'd3, rd); check("R3 write keeps word", rd, w);

    // other encoding falls back to divide 32 (R4)
    regWrite(2'd1, 32'h0);
    w = mkWord(2'b01, 5'h0a, 5'h15, 16'h0000);
    sendFrame(w, 16'h0, 32);
    waitIdle("R4");
    lastW = w;

    // R9 disabled write ignored
    regWrite(2'd0, 32'h0);
    regWrite(2'd3, mkWord(2'b10, 5'h01, 5'h01, 16'h5555));
    repeat (300) @(negedge clk);
    regRead(2'd2, rd); check("R9 idle stays", rd, 32'h4);
    regRead(2'd3, rd); check("R9 maint unchanged", rd, lastW);
    check("R9 mdc low", {31'd0, mdc}, 32'h0);

    // R10 abort mid-frame
    monIgnore = 1'b1;
    regWrite(2'd0, 32'h10);
    regWrite(2'd3, mkWord(2'b10, 5'h02, 5'h03, 16'h0000));
    repeat (400) @(negedge clk);
    regRead(2'd2, rd); check("R10 busy before abort", rd, 32'h0);
    regWrite(2'd0, 32'h0);
    repeat (3) @(negedge clk);
    regRead(2'd2, rd); check("R10 idle after abort", rd, 32'h4);
    check("R10 mdc/oe low", {30'd0, mdc, mdioOe}, 32'h0);
    monIgnore = 1'b0;

    repeat (50) @(negedge clk);
    check("R3 all frames seen", expQ.size(), 0);
    finishRun();
  end

endmodule